// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces a digital modulation code used to spread the spectrum of a clock. The code tells how far below its nominal value the frequency should be pulled. The code rises and falls in a triangle shape. The frequency is only ever pulled downward, so the code sweeps between zero (nominal frequency) and a peak value. The peak is picked by a single select input, and a direction flag reports whether the code is climbing or falling.

A full triangle lasts 4096 master clock cycles: 2048 cycles climbing and 2048 cycles falling, with each extreme held for one extra cycle at the turn. When the dither enable input is low, the code is forced to zero and the internal phase returns to its start. A new dither run therefore always begins at nominal frequency. A change on the peak select input is only adopted while the phase sits at zero, so the code never jumps partway through a ramp.

The code only modulates frequency and has no effect on how the clock's high and low halves are split. The analog stage that turns the code into an oscillator offset lies outside this block.

Top module: `dither_tri_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `offset_code` is 0 and `ramp_up` is 1.
- R2: On the cycle after any clock edge at which `dither_en` is low, `offset_code` is 0 and `ramp_up` is 1, whatever `peak_half` is.
- R3: While dither is enabled, the internal phase changes by exactly one step per cycle, except that it is held for one cycle at each end. At the full peak (`peak_half`=0), `offset_code` equals the phase.
- R4: Starting from the disabled state, `offset_code` reads k after k enabled edges, for k up to 2047. It holds 2047 for one more edge, and that is when `ramp_up` drops to 0. It then falls back to 0 and holds 0 for one edge while `ramp_up` returns to 1.
- R5: One full triangle period is 4096 cycles, and `ramp_up` is 1 for exactly 2048 of them.
- R6: When `peak_half`=1 is in effect, `offset_code` is the phase shifted right by one bit, so the peak is 1023. When `peak_half`=0 is in effect, the peak is 2047.
- R7: The value of `peak_half` is sampled only at clock edges where the phase is 0 (this includes reset and the disabled state). A change at any other point has no effect on `offset_code` until the phase returns to 0.
- R8: When dither is enabled again after being disabled, the triangle restarts from zero: the first sample reads the lowest step, 1 at full peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| dither_en | input | 1 | 1 = dither runs, 0 = code held at zero |
| peak_half | input | 1 | 1 = smaller peak (half scale), 0 = full-scale peak |
| offset_code | output | PHASE_W | Registered code for the downward frequency offset |
| ramp_up | output | 1 | Registered direction: 1 = code rising or at start, 0 = falling |

## Verification
The bench goes after the turn points of the triangle. A counter that does not hold at 2047 and 0 would shift the period to 4094 cycles, and a counter that wraps would show a jump from 2047 to 0. It toggles `peak_half` in the middle of a ramp. A design that adopts the select at once would halve or double the code in a single step. It also drops `dither_en` briefly and restarts it. A phase that is not cleared would make the restart begin in the middle of a ramp instead of at 1. Long random runs of enable and select are compared, cycle by cycle, with a reference model.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/dither_phase_ctr.sv
module dither_phase_ctr
  import dither_pkg::*;
#(
  parameter int PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_nxt,
  output dir_e               dir_q,
  output dir_e               dir_nxt
);
  localparam logic [PHASE_W-1:0] TOP = {PHASE_W{1'b1}};

  always_comb begin
    phase_nxt = phase_q;
    dir_nxt   = dir_q;
    if (!run) begin
      phase_nxt = '0;
      dir_nxt   = DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (phase_q == TOP) dir_nxt = DIR_DOWN;
      else                phase_nxt = phase_q + 1'b1;
    end else begin
      if (phase_q == '0)  dir_nxt = DIR_UP;
      else                phase_nxt = phase_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      dir_q   <= DIR_UP;
    end else begin
      phase_q <= phase_nxt;
      dir_q   <= dir_nxt;
    end
  end
endmodule

// File: rtl/dither_scale.sv
module dither_scale #(
  parameter int PHASE_W = 11
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic               half,
  output logic [PHASE_W-1:0] code
);
  always_comb code = half ? (phase >> 1) : phase;
endmodule

// File: rtl/dither_tri_gen.sv
module dither_tri_gen
  import dither_pkg::*;
#(
  parameter int PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dither_en,
  input  logic               peak_half,
  output logic [PHASE_W-1:0] offset_code,
  output logic               ramp_up
);
  logic [PHASE_W-1:0] phase_q, phase_nxt, code_nxt;
  dir_e               dir_q, dir_nxt;
  logic               sel_q, sel_nxt;

  dither_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
    .clk(clk), .rst(rst), .run(dither_en),
    .phase_q(phase_q), .phase_nxt(phase_nxt),
    .dir_q(dir_q), .dir_nxt(dir_nxt)
  );

  // select adopted only while phase rests at zero
  assign sel_nxt = (phase_q == '0) ? peak_half : sel_q;

  dither_scale #(.PHASE_W(PHASE_W)) u_scale (
    .phase(phase_nxt), .half(sel_nxt), .code(code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= peak_half;
      offset_code <= '0;
      ramp_up     <= 1'b1;
    end else begin
      sel_q       <= sel_nxt;
      offset_code <= dither_en ? code_nxt : '0;
      ramp_up     <= (dir_nxt == DIR_UP);
    end
  end
endmodule

// File: rtl/dither_tri_gen_chk.sv
module dither_tri_gen_chk #(
  parameter int PHASE_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               dither_en,
  input logic [PHASE_W-1:0] offset_code,
  input logic               ramp_up,
  input logic               sel_q
);
  localparam logic [PHASE_W-1:0] FULL = {PHASE_W{1'b1}};
  localparam logic [PHASE_W-1:0] HALF = FULL >> 1;

  assert_half_peak_R6: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> offset_code <= HALF);

  assert_disable_R2: assert property (@(posedge clk) disable iff (rst)
    !dither_en |=> (offset_code == '0) && ramp_up);

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(dither_en) && $past(dither_en, 2)) |->
      ((offset_code == $past(offset_code)) ||
       (offset_code == $past(offset_code) + 1'b1) ||
       (offset_code + 1'b1 == $past(offset_code))));

  assert_turn_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ramp_up) && $past(dither_en)) |->
      ((offset_code == '0) || (offset_code == FULL) || (offset_code == HALF)));
endmodule

bind dither_tri_gen dither_tri_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .dither_en(dither_en),
  .offset_code(offset_code), .ramp_up(ramp_up), .sel_q(sel_q)
);

// File: tb/dither_tri_gen_bench.sv
module dither_tri_gen_bench;
  localparam int W   = 11;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, sel = 1'b0;
  logic [W-1:0] offset_code;
  logic ramp_up;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dither_tri_gen #(.PHASE_W(W)) u_dither_tri_gen (
    .clk(clk), .rst(rst), .dither_en(en), .peak_half(sel),
    .offset_code(offset_code), .ramp_up(ramp_up)
  );

  // reference model
  int m_phase = 0; bit m_up = 1, m_sel = 0; int e_off = 0; bit e_dir = 1;
  always @(posedge clk) begin
    if (rst) begin
      m_sel = sel; m_phase = 0; m_up = 1; e_off = 0; e_dir = 1;
    end else begin
      if (m_phase == 0) m_sel = sel;
      if (!en) begin m_phase = 0; m_up = 1; end
      else if (m_up) begin if (m_phase == TOP) m_up = 0; else m_phase++; end
      else begin if (m_phase == 0) m_up = 1; else m_phase--; end
      e_off = en ? (m_sel ? (m_phase >> 1) : m_phase) : 0;
      e_dir = m_up;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one cycle; sample at falling edge, then compare to model
  task automatic step(bit do_model);
    @(negedge clk);
    if (do_model) begin
      chk("R3 code", int'(offset_code), e_off);
      chk("R5 dir", int'(ramp_up), int'(e_dir));
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5ns);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi_cnt, mx;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset code", int'(offset_code), 0);
    chk("R1 reset dir", int'(ramp_up), 1);
    rst = 1'b0;
    step(0);
    chk("R1 after reset code", int'(offset_code), 0);
    chk("R1 after reset dir", int'(ramp_up), 1);

    // full peak ramp up, directed
    en = 1'b1; sel = 1'b0;
    for (int k = 1; k <= TOP; k++) step(1);
    chk("R4 peak reached", int'(offset_code), TOP);
    chk("R4 dir still up", int'(ramp_up), 1);
    step(1);
    chk("R4 hold at peak", int'(offset_code), TOP);
    chk("R4 dir down", int'(ramp_up), 0);
    for (int k = 0; k < TOP; k++) step(1);
    chk("R4 back at zero", int'(offset_code), 0);
    step(1);
    chk("R4 hold at zero", int'(offset_code), 0);
    chk("R4 dir up again", int'(ramp_up), 1);

    // one full period from zero: count dir high samples
    hi_cnt = 0; mx = 0;
    for (int k = 0; k < 4096; k++) begin
      step(1);
      if (ramp_up) hi_cnt++;
      if (int'(offset_code) > mx) mx = int'(offset_code);
    end
    chk("R5 dir high count", hi_cnt, 2048);
    chk("R5 period end code", int'(offset_code), 0);
    chk("R6 full peak max", mx, TOP);

    // disable with select toggling: code must stay zero
    en = 1'b0; sel = 1'b1;
    step(1);
    chk("R2 disabled code", int'(offset_code), 0);
    sel = 1'b0;
    step(1); step(1);
    chk("R2 disabled code hold", int'(offset_code), 0);
    chk("R2 disabled dir", int'(ramp_up), 1);

    // restart from zero, then mid-ramp select change ignored
    en = 1'b1; sel = 1'b0;
    step(1);
    chk("R8 restart first step", int'(offset_code), 1);
    for (int k = 0; k < 99; k++) step(1);
    chk("R7 before select change", int'(offset_code), 100);
    sel = 1'b1;
    step(1);
    chk("R7 select ignored mid ramp", int'(offset_code), 101);

    // half peak from a clean start
    en = 1'b0; step(1);
    en = 1'b1; mx = 0;
    for (int k = 0; k < 4096; k++) begin
      step(1);
      if (int'(offset_code) > mx) mx = int'(offset_code);
    end
    chk("R6 half peak max", mx, TOP >> 1);

    // random enable / select traffic
    for (int k = 0; k < 40000; k++) begin
      step(1);
      en  = ($urandom_range(0, 999) != 0);
      if ($urandom_range(0, 299) == 0) sel = ~sel;
    end
    en = 1'b0;
    step(1);
    chk("R2 final disable", int'(offset_code), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule